// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is one 8-pin general purpose I/O port, seen by the processor as three per-pin registers on a simple single-cycle register bus. The three registers are a data latch, a direction mask and an option mask. Bit N of each register controls pin N. The block drives an output-enable vector and an output-value vector to the pad buffers. It samples the pad inputs through a two-stage synchronizer, and it exports both the synchronized pin levels and a per-pin interrupt-enable vector to a separate interrupt unit.

A read of the data register merges two sources. Bits whose pin is an input return the synchronized pad level. Bits whose pin is an output return the latch. A write to the data register always updates the latch, including for input pins. Software can therefore preload the level a pin will drive and then flip the direction bit, and the pad comes up driving that level with no glitch.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register holds 0, so `pad_oe_o`, `irq_en_o` and `pin_sync_o` are all 0 and reads of every address return 0.
- R2: A write to address 1 (direction) loads `wdata_i` into the direction mask, and it appears on `pad_oe_o` one clock later. A bit value of 1 means output and 0 means input.
- R3: A write to address 0 (data) while a pin is an input changes only the latch and leaves `pad_oe_o` unchanged. When the direction bit is later set, `pad_out_o` carries the preloaded value in the same cycle that `pad_oe_o` rises.
- R4: A read of address 0 returns the synchronized pad value in every bit whose direction bit is 0.
- R5: A read of address 0 returns the latch value in every bit whose direction bit is 1, whatever the pad level.
- R6: `irq_en_o` bit N is 1 exactly when direction bit N is 0 and option bit N is 1.
- R7: `pin_sync_o` equals `pad_in_i` delayed by exactly two clock edges.
- R8: Address 3 is reserved. Reads of it return 0, and writes to it change no register.
- R9: Reads of address 1 and address 2 (option) return the value last written there.
- R10: `pad_out_o` always equals the data latch. A data write is visible on it one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select: 0 data, 1 direction, 2 option, 3 reserved |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| pad_in_i | input | 8 | Asynchronous pad input levels |
| pad_out_o | output | 8 | Level driven on each pad |
| pad_oe_o | output | 8 | Pad output enable, 1 = driving |
| pin_sync_o | output | 8 | Synchronized pad levels for the interrupt unit |
| irq_en_o | output | 8 | Per-pin interrupt enable for the interrupt unit |

## Verification
The bench preloads the latch while the pins are inputs and then switches them to outputs. A design that let a data write touch the enable would drive the pad early, and one that cleared the latch would come up at the wrong level. It reads the data register with a mixed direction mask while the pads carry a pattern that differs from the latch, which catches a read mux that picks the wrong source per bit. It also measures synchronizer latency edge by edge, so one stage too few or too many shows up as an early or stale value. It confirms that output pins never report an interrupt enable, and that the reserved address neither reads nonzero nor aliases onto a real register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_OPT  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] latch_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] opt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      opt_o   <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        REG_DATA: latch_o <= wdata_i; // written regardless of direction
        REG_DIR:  dir_o   <= wdata_i;
        REG_OPT:  opt_o   <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] opt_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] rdata_o
);
  logic [NUM_PINS-1:0] data_view;

  for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
    assign data_view[b] = dir_i[b] ? latch_i[b] : pin_i[b];
  end

  always_comb begin
    unique case (sel_i)
      REG_DATA: rdata_o = data_view;
      REG_DIR:  rdata_o = dir_i;
      REG_OPT:  rdata_o = opt_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AddrW      = $bits(reg_sel_e)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AddrW-1:0]    addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pin_sync_o,
  output logic [NUM_PINS-1:0] irq_en_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] latch, dir, opt, pin_s;

  assign sel = reg_sel_e'(addr_i);

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_s)
  );

  gpio_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (req_i & we_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .latch_o (latch),
    .dir_o   (dir),
    .opt_o   (opt)
  );

  gpio_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .sel_i   (sel),
    .latch_i (latch),
    .dir_i   (dir),
    .opt_i   (opt),
    .pin_i   (pin_s),
    .rdata_o (rdata_o)
  );

  assign pad_out_o  = latch;
  assign pad_oe_o   = dir;
  assign pin_sync_o = pin_s;
  assign irq_en_o   = ~dir & opt;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [1:0]          addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pin_sync_o,
  input logic [NUM_PINS-1:0] irq_en_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_oe_o == '0 && irq_en_o == '0)); // R1

  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd1) |=> pad_oe_o == $past(wdata_i)); // R2

  AST_DATA_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd0) |=> $stable(pad_oe_o)); // R3

  AST_OUT_BITS_READ_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd0) |-> ((rdata_o & pad_oe_o) == (pad_out_o & pad_oe_o))); // R5

  AST_NO_IRQ_ON_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_o & pad_oe_o) == '0); // R6

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> pin_sync_o == $past(pad_in_i, 2)); // R7

  AST_RSVD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd3) |-> rdata_o == '0); // R8

  AST_DATA_WRITE_TO_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd0) |=> pad_out_o == $past(wdata_i)); // R10
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pad_in_i   (pad_in_i),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .pin_sync_o (pin_sync_o),
  .irq_en_o   (irq_en_o)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] pad_in_i = '0;
  logic [7:0] rdata_o, pad_out_o, pad_oe_o, pin_sync_o, irq_en_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .pin_sync_o(pin_sync_o), .irq_en_o(irq_en_o)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic settle_pins(input logic [7:0] v);
    @(negedge clk_i);
    pad_in_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1", "oe after reset", pad_oe_o, 8'h00);
    check("R1", "irq_en after reset", irq_en_o, 8'h00);
    check("R1", "pin_sync after reset", pin_sync_o, 8'h00);
    bus_read(2'd1, d); check("R1", "dir read", d, 8'h00);
    bus_read(2'd2, d); check("R1", "opt read", d, 8'h00);
    bus_read(2'd0, d); check("R1", "data read", d, 8'h00);
  endtask

  task automatic t_direction;
    logic [7:0] d;
    bus_write(2'd1, 8'hA5);
    check("R2", "oe after dir write", pad_oe_o, 8'hA5);
    bus_read(2'd1, d); check("R9", "dir readback", d, 8'hA5);
    bus_write(2'd1, 8'h00);
    check("R2", "oe cleared", pad_oe_o, 8'h00);
  endtask

  task automatic t_preload;
    logic [7:0] d;
    settle_pins(8'h00);
    bus_write(2'd0, 8'h3C);
    check("R3", "oe unchanged by data write", pad_oe_o, 8'h00);
    bus_read(2'd0, d); check("R4", "input read shows pins not latch", d, 8'h00);
    bus_write(2'd1, 8'hFF);
    check("R3", "oe after switch", pad_oe_o, 8'hFF);
    check("R3", "preloaded level on pad", pad_out_o, 8'h3C);
    bus_read(2'd0, d); check("R5", "output read shows latch", d, 8'h3C);
  endtask

  task automatic t_mixed;
    logic [7:0] d;
    bus_write(2'd1, 8'h0F);
    bus_write(2'd0, 8'h05);
    settle_pins(8'hFA);
    bus_read(2'd0, d); check("R4", "mixed read upper input bits", d & 8'hF0, 8'hF0);
    check("R5", "mixed read lower output bits", d & 8'h0F, 8'h05);
    settle_pins(8'h0F);
    bus_read(2'd0, d); check("R4", "mixed read after pin change", d, 8'h05);
  endtask

  task automatic t_sync_latency;
    @(negedge clk_i); pad_in_i = 8'h00;
    repeat (3) @(negedge clk_i);
    pad_in_i = 8'h81;
    @(negedge clk_i);
    check("R7", "sync after one edge", pin_sync_o, 8'h00);
    @(negedge clk_i);
    check("R7", "sync after two edges", pin_sync_o, 8'h81);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    bus_write(2'd1, 8'h0F);
    bus_write(2'd2, 8'hFF);
    check("R6", "irq_en input-only", irq_en_o, 8'hF0);
    bus_read(2'd2, d); check("R9", "opt readback", d, 8'hFF);
    bus_write(2'd2, 8'h3C);
    check("R6", "irq_en partial option", irq_en_o, 8'h30);
    bus_write(2'd1, 8'h00);
    check("R6", "irq_en all inputs", irq_en_o, 8'h3C);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    bus_write(2'd1, 8'h99);
    bus_write(2'd2, 8'h66);
    bus_write(2'd0, 8'h11);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, d); check("R8", "reserved reads zero", d, 8'h00);
    bus_read(2'd1, d); check("R8", "dir untouched", d, 8'h99);
    bus_read(2'd2, d); check("R8", "opt untouched", d, 8'h66);
    check("R8", "latch untouched", pad_out_o, 8'h11);
  endtask

  task automatic t_out_tracks;
    bus_write(2'd1, 8'hFF);
    bus_write(2'd0, 8'h5A);
    check("R10", "pad_out after data write", pad_out_o, 8'h5A);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'hC3);
    check("R10", "pad_out in input mode", pad_out_o, 8'hC3);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_direction();
    t_preload();
    t_mixed();
    t_sync_latency();
    t_irq();
    t_reserved();
    t_out_tracks();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule